// File: doc/BRIEF.md
# Debug Entry Cause Status Register

This block records why a processor core went into debug mode and shows the core's present operating mode. The result is a single 16-bit read-only status word. Around the block, the pipeline, the trace counter and the breakpoint comparators produce single-cycle event pulses and a debug-entry strobe. The block turns those pulses into sticky cause flags. Most causes are recorded only in the cycle where debug mode is actually entered. Trace FIFO freezes and the two sequential-breakpoint arming steps are recorded as soon as they occur.

A memory breakpoint request can arrive before the core gets to debug mode. For that reason the block keeps such a request in a pending latch until the next entry strobe. At that entry the memory-breakpoint flag is set, whatever the immediate reason for the entry. The flags are cleared in only two ways: by the test-logic reset, or by a debug exit strobe qualified by both the GO and the EX controls. The processor-mode field is not latched. It follows its input directly.

Top module: `dbg_cause_status`

## Requirements
- R1: `status_o[15:10]` always reads zero. Flags sit at these bit positions: 9 hardware request, 8 debug-request control, 7 memory breakpoint, 6 breakpoint instruction, 5 trace, 4 FIFO freeze, 3 sequential stage B, 2 sequential stage A. Bits 1:0 hold the mode field.
- R2: A system reset (`rst`) or a test-logic reset (`tl_rst_i`) clears all eight flags and the pending breakpoint latch. The result is visible after the next clock edge.
- R3: When the entry strobe comes with `ext_dbg_req_i` or `dbg_pin_i` high, bit 9 is set.
- R4: When the entry strobe comes with `dreq_ctl_i` high, bit 8 is set.
- R5: A `mem_brk_req_i` pulse without an entry leaves bit 7 clear and is kept pending. Bit 7 is set at the next entry strobe, or at an entry in the same cycle as the request. An entry empties the pending latch.
- R6: When the entry strobe comes with `swbk_exec_i` high, bit 6 is set.
- R7: When the entry strobe comes with both `trace_zero_i` and `trace_en_i` high, bit 5 is set. If `trace_en_i` is low, bit 5 stays clear.
- R8: `fifo_frz_i` sets bit 4 on its own, with no entry strobe.
- R9: When `seq_en_i` is high, `brk_a_i` sets bit 2. When `seq_en_i` is high and bit 2 was already set before that cycle, `brk_b_i` sets bit 3. With `seq_en_i` low, both events are ignored.
- R10: A `dbg_exit_i` strobe with `exit_go_i` and `exit_ex_i` both high clears all flags and the pending latch. An exit missing either qualifier changes nothing.
- R11: When a clear and a set event fall in the same cycle, the clear takes effect.
- R12: A set flag stays set until one of the clears in R2 or R10 occurs.
- R13: `status_o[1:0]` equals `cpu_mode_i` in the same cycle, including while in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| tl_rst_i | input | 1 | Synchronous test-logic reset, clears flags |
| dbg_enter_i | input | 1 | Core enters debug mode this cycle |
| ext_dbg_req_i | input | 1 | External debug request line |
| dbg_pin_i | input | 1 | Debug-enable pin request |
| dreq_ctl_i | input | 1 | Debug-request control bit level |
| mem_brk_req_i | input | 1 | Memory breakpoint request pulse |
| swbk_exec_i | input | 1 | Breakpoint instruction executed |
| trace_zero_i | input | 1 | Trace counter reached zero |
| trace_en_i | input | 1 | Trace mode enabled |
| fifo_frz_i | input | 1 | Trace FIFO freeze event |
| seq_en_i | input | 1 | Sequential breakpoint mode enabled |
| brk_a_i | input | 1 | Breakpoint A event |
| brk_b_i | input | 1 | Breakpoint B event |
| dbg_exit_i | input | 1 | Debug-exit strobe |
| exit_go_i | input | 1 | GO qualifier of the exit |
| exit_ex_i | input | 1 | EX qualifier of the exit |
| cpu_mode_i | input | 2 | Live processor mode |
| status_o | output | 16 | Packed status word |

## Verification
The assertions check the following on every cycle:
- the upper six bits stay zero;
- both clear paths take effect, even when a set event falls in the same cycle;
- flags are sticky;
- an incomplete exit leaves the flags as they were;
- the hardware-request flag and the FIFO-freeze flag set;
- stage B never rises without stage A;
- the memory-breakpoint flag rises only after an entry strobe.

Some behaviour depends on a history of several cycles, and only the bench's scenarios show it:
- a breakpoint request is held across idle cycles;
- an entry consumes the pending request;
- a clear empties the pending latch;
- a trace zero with trace disabled has no effect;
- sequential events are ignored when sequential mode is off.

// File: rtl/dbg_cause_pkg.sv
package dbg_cause_pkg;

    localparam int STATUS_W  = 16;
    localparam int MODE_W    = 2;
    localparam int NUM_FLAGS = 8;
    localparam int FLAG_LSB  = MODE_W;
    localparam int FLAG_MSB  = MODE_W + NUM_FLAGS - 1;
    localparam int PAD_W     = STATUS_W - MODE_W - NUM_FLAGS;

    // Position of each cause within the flag vector (word bit = index + FLAG_LSB)
    typedef enum int unsigned {
        FL_SEQA  = 0,
        FL_SEQB  = 1,
        FL_FRZ   = 2,
        FL_TRACE = 3,
        FL_SWBK  = 4,
        FL_MBRK  = 5,
        FL_DREQ  = 6,
        FL_HWREQ = 7
    } flag_idx_e;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
    typedef logic [MODE_W-1:0]    mode_t;
    typedef logic [STATUS_W-1:0]  status_t;

    typedef struct packed {
        logic hw_req;
        logic de_pin;
        logic dreq_ctl;
        logic swbk;
        logic trace_zero;
        logic trace_en;
        logic fifo_frz;
        logic seq_en;
        logic brk_a;
        logic brk_b;
    } cause_in_t;

    typedef struct packed {
        logic strobe;
        logic go;
        logic ex;
    } exit_req_t;

    function automatic logic exit_clears(exit_req_t e);
        return e.strobe & e.go & e.ex;
    endfunction

    function automatic status_t pack_status(flag_vec_t f, mode_t m);
        return {{PAD_W{1'b0}}, f, m};
    endfunction

endpackage

// File: rtl/dbg_brk_pend.sv
module dbg_brk_pend (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic req_i,
    input  logic enter_i,
    output logic hit_o
);

    logic pend_q;

    // A request waits here until an entry consumes it or a clear drops it
    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            pend_q <= 1'b0;
        end else if (enter_i) begin
            pend_q <= 1'b0;
        end else if (req_i) begin
            pend_q <= 1'b1;
        end
    end

    assign hit_o = enter_i & (pend_q | req_i);

endmodule

// File: rtl/dbg_cause_decode.sv
module dbg_cause_decode
    import dbg_cause_pkg::*;
(
    input  cause_in_t cause_i,
    input  logic      enter_i,
    input  logic      brk_hit_i,
    input  logic      seqa_set_i,
    output flag_vec_t set_o
);

    always_comb begin
        set_o           = '0;
        set_o[FL_HWREQ] = enter_i & (cause_i.hw_req | cause_i.de_pin);
        set_o[FL_DREQ]  = enter_i & cause_i.dreq_ctl;
        set_o[FL_MBRK]  = brk_hit_i;
        set_o[FL_SWBK]  = enter_i & cause_i.swbk;
        set_o[FL_TRACE] = enter_i & cause_i.trace_zero & cause_i.trace_en;
        set_o[FL_FRZ]   = cause_i.fifo_frz;
        set_o[FL_SEQA]  = cause_i.seq_en & cause_i.brk_a;
        set_o[FL_SEQB]  = cause_i.seq_en & cause_i.brk_b & seqa_set_i;
    end

endmodule

// File: rtl/dbg_flag_bank.sv
module dbg_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic [N-1:0] set_i,
    output logic [N-1:0] flag_o
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                flag_o[g] <= 1'b0;
            end else if (set_i[g]) begin
                flag_o[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dbg_cause_status.sv
module dbg_cause_status
    import dbg_cause_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tl_rst_i,
    input  logic                dbg_enter_i,
    input  logic                ext_dbg_req_i,
    input  logic                dbg_pin_i,
    input  logic                dreq_ctl_i,
    input  logic                mem_brk_req_i,
    input  logic                swbk_exec_i,
    input  logic                trace_zero_i,
    input  logic                trace_en_i,
    input  logic                fifo_frz_i,
    input  logic                seq_en_i,
    input  logic                brk_a_i,
    input  logic                brk_b_i,
    input  logic                dbg_exit_i,
    input  logic                exit_go_i,
    input  logic                exit_ex_i,
    input  logic [MODE_W-1:0]   cpu_mode_i,
    output logic [STATUS_W-1:0] status_o
);

    cause_in_t cause;
    exit_req_t exit_req;
    flag_vec_t set_vec;
    flag_vec_t flags;
    logic      clr;
    logic      brk_hit;

    assign cause = '{
        hw_req:     ext_dbg_req_i,
        de_pin:     dbg_pin_i,
        dreq_ctl:   dreq_ctl_i,
        swbk:       swbk_exec_i,
        trace_zero: trace_zero_i,
        trace_en:   trace_en_i,
        fifo_frz:   fifo_frz_i,
        seq_en:     seq_en_i,
        brk_a:      brk_a_i,
        brk_b:      brk_b_i
    };

    assign exit_req = '{strobe: dbg_exit_i, go: exit_go_i, ex: exit_ex_i};
    assign clr      = tl_rst_i | exit_clears(exit_req);

    dbg_brk_pend u_pend (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (clr),
        .req_i   (mem_brk_req_i),
        .enter_i (dbg_enter_i),
        .hit_o   (brk_hit)
    );

    dbg_cause_decode u_decode (
        .cause_i    (cause),
        .enter_i    (dbg_enter_i),
        .brk_hit_i  (brk_hit),
        .seqa_set_i (flags[FL_SEQA]),
        .set_o      (set_vec)
    );

    dbg_flag_bank #(.N(NUM_FLAGS)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr),
        .set_i  (set_vec),
        .flag_o (flags)
    );

    assign status_o = pack_status(flags, cpu_mode_i);

endmodule

// File: rtl/dbg_cause_status_chk.sv
module dbg_cause_status_chk
    import dbg_cause_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                tl_rst_i,
    input logic                dbg_enter_i,
    input logic                ext_dbg_req_i,
    input logic                dbg_pin_i,
    input logic                fifo_frz_i,
    input logic                brk_a_i,
    input logic                brk_b_i,
    input logic                dbg_exit_i,
    input logic                exit_go_i,
    input logic                exit_ex_i,
    input logic [STATUS_W-1:0] status_o
);

    logic full_exit;
    assign full_exit = dbg_exit_i & exit_go_i & exit_ex_i;

    p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        status_o[STATUS_W-1:FLAG_MSB+1] == '0);

    p_sysreset_r2: assert property (@(posedge clk)
        rst |=> status_o[FLAG_MSB:FLAG_LSB] == '0);

    p_tlreset_r2: assert property (@(posedge clk) disable iff (rst)
        tl_rst_i |=> status_o[FLAG_MSB:FLAG_LSB] == '0);

    // Also covers R11: any set event in the same cycle loses
    p_exit_clear_r10: assert property (@(posedge clk) disable iff (rst)
        full_exit |=> status_o[FLAG_MSB:FLAG_LSB] == '0);

    p_partial_exit_r10: assert property (@(posedge clk) disable iff (rst)
        (dbg_exit_i && !(exit_go_i && exit_ex_i) && !tl_rst_i && !dbg_enter_i
         && !fifo_frz_i && !brk_a_i && !brk_b_i)
        |=> $stable(status_o[FLAG_MSB:FLAG_LSB]));

    p_hw_set_r3: assert property (@(posedge clk) disable iff (rst)
        (dbg_enter_i && (ext_dbg_req_i || dbg_pin_i) && !tl_rst_i && !full_exit)
        |=> status_o[FLAG_LSB + FL_HWREQ]);

    p_frz_set_r8: assert property (@(posedge clk) disable iff (rst)
        (fifo_frz_i && !tl_rst_i && !full_exit) |=> status_o[FLAG_LSB + FL_FRZ]);

    p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (!tl_rst_i && !full_exit) |=>
        ((status_o[FLAG_MSB:FLAG_LSB] & $past(status_o[FLAG_MSB:FLAG_LSB]))
         == $past(status_o[FLAG_MSB:FLAG_LSB])));

    p_seqb_order_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[FLAG_LSB + FL_SEQB]) |-> status_o[FLAG_LSB + FL_SEQA]);

    p_mbrk_on_entry_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[FLAG_LSB + FL_MBRK]) |-> $past(dbg_enter_i));

endmodule

bind dbg_cause_status dbg_cause_status_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .tl_rst_i      (tl_rst_i),
    .dbg_enter_i   (dbg_enter_i),
    .ext_dbg_req_i (ext_dbg_req_i),
    .dbg_pin_i     (dbg_pin_i),
    .fifo_frz_i    (fifo_frz_i),
    .brk_a_i       (brk_a_i),
    .brk_b_i       (brk_b_i),
    .dbg_exit_i    (dbg_exit_i),
    .exit_go_i     (exit_go_i),
    .exit_ex_i     (exit_ex_i),
    .status_o      (status_o)
);

// File: tb/dbg_cause_status_bench.sv
module dbg_cause_status_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tl_rst_i, dbg_enter_i, ext_dbg_req_i, dbg_pin_i, dreq_ctl_i;
    logic        mem_brk_req_i, swbk_exec_i, trace_zero_i, trace_en_i, fifo_frz_i;
    logic        seq_en_i, brk_a_i, brk_b_i, dbg_exit_i, exit_go_i, exit_ex_i;
    logic [1:0]  cpu_mode_i;
    logic [15:0] status_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dbg_cause_status u_dbg_cause_status (.*);

    // Stimulus bit masks
    localparam logic [17:0] S_TLR = 18'h1 << 17;
    localparam logic [17:0] S_ENT = 18'h1 << 16;
    localparam logic [17:0] S_HW  = 18'h1 << 15;
    localparam logic [17:0] S_PIN = 18'h1 << 14;
    localparam logic [17:0] S_DRQ = 18'h1 << 13;
    localparam logic [17:0] S_MBK = 18'h1 << 12;
    localparam logic [17:0] S_SWB = 18'h1 << 11;
    localparam logic [17:0] S_TZ  = 18'h1 << 10;
    localparam logic [17:0] S_TEN = 18'h1 << 9;
    localparam logic [17:0] S_FRZ = 18'h1 << 8;
    localparam logic [17:0] S_SEN = 18'h1 << 7;
    localparam logic [17:0] S_BRA = 18'h1 << 6;
    localparam logic [17:0] S_BRB = 18'h1 << 5;
    localparam logic [17:0] S_EXT = 18'h1 << 4;
    localparam logic [17:0] S_GO  = 18'h1 << 3;
    localparam logic [17:0] S_EX  = 18'h1 << 2;
    localparam logic [17:0] S_CLR = S_EXT | S_GO | S_EX;

    typedef struct packed {
        logic [7:0]  req;
        logic [17:0] stim;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VECS [NV] = '{
        '{8'd13, 18'd2,                   16'h002}, // R13 live mode
        '{8'd3,  S_ENT | S_HW,            16'h200}, // R3 external request
        '{8'd10, S_EXT | S_GO,            16'h200}, // R10 exit lacks EX
        '{8'd10, S_EXT | S_EX,            16'h200}, // R10 exit lacks GO
        '{8'd10, S_CLR,                   16'h000}, // R10 full exit
        '{8'd3,  S_ENT | S_PIN,           16'h200}, // R3 pin request
        '{8'd4,  S_ENT | S_DRQ | 18'd1,   16'h301}, // R4 + R12 sticky
        '{8'd10, S_CLR,                   16'h000},
        '{8'd5,  S_MBK,                   16'h000}, // R5 no entry
        '{8'd13, 18'd3,                   16'h003}, // R5 held, R13
        '{8'd6,  S_ENT | S_SWB,           16'h0C0}, // R6 + R5 pending hit
        '{8'd10, S_CLR,                   16'h000},
        '{8'd5,  S_ENT,                   16'h000}, // R5 pending consumed
        '{8'd5,  S_ENT | S_MBK,           16'h080}, // R5 same-cycle
        '{8'd10, S_CLR,                   16'h000},
        '{8'd7,  S_ENT | S_TZ,            16'h000}, // R7 trace disabled
        '{8'd7,  S_ENT | S_TZ | S_TEN,    16'h020}, // R7
        '{8'd8,  S_FRZ,                   16'h030}, // R8
        '{8'd10, S_CLR,                   16'h000},
        '{8'd8,  S_FRZ,                   16'h010}, // R8 no entry
        '{8'd11, S_CLR | S_FRZ,           16'h000}, // R11 clear wins
        '{8'd9,  S_BRA,                   16'h000}, // R9 seq off
        '{8'd9,  S_SEN | S_BRB,           16'h000}, // R9 B before A
        '{8'd9,  S_SEN | S_BRA,           16'h004}, // R9 A
        '{8'd9,  S_SEN | S_BRB,           16'h00C}, // R9 B after A
        '{8'd10, S_CLR,                   16'h000},
        '{8'd9,  S_SEN | S_BRA | S_BRB,   16'h004}, // R9 same cycle
        '{8'd11, S_TLR | S_ENT | S_HW,    16'h000}, // R11/R2 test reset wins
        '{8'd5,  S_MBK,                   16'h000},
        '{8'd2,  S_TLR,                   16'h000}, // R2 drops pending
        '{8'd2,  S_ENT,                   16'h000}, // R2 pending gone
        '{8'd11, S_MBK | S_CLR,           16'h000}, // R11
        '{8'd11, S_ENT,                   16'h000}  // R11 pending not kept
    };

    task automatic drive(input logic [17:0] s);
        tl_rst_i      = s[17];
        dbg_enter_i   = s[16];
        ext_dbg_req_i = s[15];
        dbg_pin_i     = s[14];
        dreq_ctl_i    = s[13];
        mem_brk_req_i = s[12];
        swbk_exec_i   = s[11];
        trace_zero_i  = s[10];
        trace_en_i    = s[9];
        fifo_frz_i    = s[8];
        seq_en_i      = s[7];
        brk_a_i       = s[6];
        brk_b_i       = s[5];
        dbg_exit_i    = s[4];
        exit_go_i     = s[3];
        exit_ex_i     = s[2];
        cpu_mode_i    = s[1:0];
    endtask

    task automatic check(input int req, input logic [15:0] exp);
        n_checks++;
        if (status_o !== exp) begin
            n_fail++;
            $display("FAIL R%0d: status_o=%h expected %h", req, status_o, exp);
        end
    endtask

    initial begin
        drive(18'd3);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(2, 16'h003);   // R2 reset state, R13 mode live in reset
        rst = 1'b0;

        drive(VECS[0].stim);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check(int'(VECS[i].req), VECS[i].exp);
            if (i + 1 < NV) drive(VECS[i + 1].stim);
        end

        // R1: every cause at once, then stage B on the following cycle
        drive(S_ENT | S_HW | S_DRQ | S_MBK | S_SWB | S_TZ | S_TEN | S_FRZ
              | S_SEN | S_BRA | S_BRB | 18'd3);
        @(negedge clk);
        check(1, 16'h3F7);
        @(negedge clk);
        check(1, 16'h3FF);
        check(1, {status_o[15:10] == 6'd0 ? 16'h3FF : 16'h0000}); // R1 pad bits

        // R2: system reset clears flags, mode still live
        drive(18'd1);
        rst = 1'b1;
        @(negedge clk);
        check(2, 16'h001);
        rst = 1'b0;
        drive(18'd2);
        @(negedge clk);
        check(12, 16'h002);  // R12 nothing sets after reset without events

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule